// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Feedback Divider

This block is the programmable feedback divider of a frequency synthesiser loop. It divides an incoming high-rate clock by a 17-bit ratio N and delivers one short pulse per divide cycle to the phase comparator. Inside, the ratio is split into a 13-bit main count M (upper bits) and a 4-bit swallow count A (lower bits). A prescaler counts 17 input ticks per step while the swallow count is nonzero and 16 ticks per step after that. The main counter counts prescaler steps, so one divide cycle lasts 16*M + A input ticks.

An optional halving stage sits in front of the prescaler. When the halving select is high, only every second input cycle counts, which doubles the total ratio. The select is meant to be static. A ratio below the minimum is raised to the minimum, which keeps M at or above A. A new ratio only takes effect at the end of a complete divide cycle, so the loop never sees a cycle of mixed length. A second output toggles at every pulse. It gives a half-rate square wave that can be routed out for test.

Top module: `pulse_swallow_div`

## Requirements
- R1: While reset is held, and until the first pulse, `div_out` and `div_half` are 0.
- R2: With `halve`=0 and a ratio whose low 4 bits are zero (for example 480), consecutive `div_out` pulses are exactly N clock cycles apart.
- R3: With `halve`=0 and a nonzero low field A, the period is 16*M + A, where M = `ratio[16:4]` and A = `ratio[3:0]` (for example 327 gives M=20, A=7).
- R4: Reset is released and the next rising edge loads the ratio. The first pulse is then high during the cycle that follows the N-th rising edge after that load edge.
- R5: Each `div_out` pulse is high for exactly one clock cycle.
- R6: With `halve`=1, consecutive pulses are 2*N clock cycles apart.
- R7: A ratio below 240, including 0, divides by 240.
- R8: A ratio change applied partway through a divide cycle does not change that cycle. The cycle after the next pulse uses the new ratio.
- R9: `div_half` inverts in the same cycle that each `div_out` pulse appears and holds its level otherwise. It is 1 during the first pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock being divided |
| rst_n | input | 1 | Active-low asynchronous reset |
| ratio | input | 17 | Division ratio N; M = bits 16:4, A = bits 3:0 |
| halve | input | 1 | 1 inserts the divide-by-two stage (static select) |
| div_out | output | 1 | One-cycle pulse at the end of every divide cycle |
| div_half | output | 1 | Toggles on every pulse; half-rate test copy |

## Verification
After reset is released, one edge loads the counters. The first pulse then becomes visible N+1 falling edges later. Each following pulse lands exactly N falling edges after the previous one, or 2*N with halving on. The bench drives every input on the falling edge and counts falling edges until `div_out` is seen high, so each period and latency is compared as an exact count. The mid-cycle ratio change is applied a known number of falling edges after a pulse, so the remaining old-ratio cycles and the following new-ratio period each have an exact expected value. The pulse width and the `div_half` level are checked on the falling edge of the pulse cycle and the one after it.

// File: rtl/psd_pkg.sv
package psd_pkg;
    localparam int PSD_MAIN_W  = 13;
    localparam int PSD_SWAL_W  = 4;
    localparam int PSD_MIN_DIV = 240;
endpackage

// File: rtl/psd_half_stage.sv
module psd_half_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic halve,
    output logic tick_en
);
    typedef struct packed {
        logic phase;
    } half_st_t;

    half_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.phase = halve ? ~st_q.phase : 1'b0;
        tick_en    = halve ? st_q.phase : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/psd_ratio_split.sv
module psd_ratio_split #(
    parameter int MAIN_W  = 13,
    parameter int SWAL_W  = 4,
    parameter int MIN_DIV = 240
) (
    input  logic [MAIN_W+SWAL_W-1:0] ratio,
    output logic [MAIN_W-1:0]        main_val,
    output logic [SWAL_W-1:0]        swal_val
);
    localparam int TOT_W = MAIN_W + SWAL_W;
    localparam logic [TOT_W-1:0] MIN_V = TOT_W'(MIN_DIV);

    logic [TOT_W-1:0] eff;

    always_comb begin
        eff      = (ratio < MIN_V) ? MIN_V : ratio;
        main_val = eff[TOT_W-1:SWAL_W];
        swal_val = eff[SWAL_W-1:0];
    end
endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler #(
    parameter int SWAL_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic restart,
    input  logic swallow,
    output logic wrap
);
    localparam int BASE = 2 ** SWAL_W;
    localparam int PC_W = $clog2(BASE + 1);
    localparam logic [PC_W-1:0] LAST_LO = PC_W'(BASE - 1);
    localparam logic [PC_W-1:0] LAST_HI = PC_W'(BASE);

    typedef struct packed {
        logic [PC_W-1:0] pc;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic [PC_W-1:0] last;

    always_comb begin
        st_d = st_q;
        last = swallow ? LAST_HI : LAST_LO;
        wrap = tick_en && !restart && (st_q.pc == last);
        if (restart)      st_d.pc = '0;
        else if (wrap)    st_d.pc = '0;
        else if (tick_en) st_d.pc = st_q.pc + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/psd_swallow_ctrl.sv
module psd_swallow_ctrl #(
    parameter int MAIN_W = 13,
    parameter int SWAL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wrap,
    input  logic [MAIN_W-1:0] main_val,
    input  logic [SWAL_W-1:0] swal_val,
    output logic              swallow,
    output logic              loading,
    output logic              pulse,
    output logic              half,
    output logic [MAIN_W-1:0] main_cnt,
    output logic [SWAL_W-1:0] swal_cnt
);
    localparam logic [MAIN_W-1:0] ONE = MAIN_W'(1);

    typedef struct packed {
        logic [MAIN_W-1:0] m;
        logic [SWAL_W-1:0] a;
        logic              ld;
        logic              out;
        logic              hlf;
    } sw_st_t;

    sw_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.out = 1'b0;
        if (st_q.ld) begin
            st_d.m  = main_val;
            st_d.a  = swal_val;
            st_d.ld = 1'b0;
        end else if (wrap) begin
            if (st_q.m == ONE) begin
                st_d.m   = main_val;
                st_d.a   = swal_val;
                st_d.out = 1'b1;
                st_d.hlf = ~st_q.hlf;
            end else begin
                st_d.m = st_q.m - 1'b1;
                if (st_q.a != '0) st_d.a = st_q.a - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.ld <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign swallow  = (st_q.a != '0);
    assign loading  = st_q.ld;
    assign pulse    = st_q.out;
    assign half     = st_q.hlf;
    assign main_cnt = st_q.m;
    assign swal_cnt = st_q.a;
endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div #(
    parameter int MAIN_W  = psd_pkg::PSD_MAIN_W,
    parameter int SWAL_W  = psd_pkg::PSD_SWAL_W,
    parameter int MIN_DIV = psd_pkg::PSD_MIN_DIV
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [MAIN_W+SWAL_W-1:0] ratio,
    input  logic                     halve,
    output logic                     div_out,
    output logic                     div_half
);
    logic              tick_en;
    logic              wrap;
    logic              swallow;
    logic              loading;
    logic [MAIN_W-1:0] main_val;
    logic [SWAL_W-1:0] swal_val;
    logic [MAIN_W-1:0] main_cnt;
    logic [SWAL_W-1:0] swal_cnt;

    psd_half_stage u_half (
        .clk(clk), .rst_n(rst_n), .halve(halve), .tick_en(tick_en)
    );

    psd_ratio_split #(.MAIN_W(MAIN_W), .SWAL_W(SWAL_W), .MIN_DIV(MIN_DIV)) u_split (
        .ratio(ratio), .main_val(main_val), .swal_val(swal_val)
    );

    psd_prescaler #(.SWAL_W(SWAL_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .restart(loading),
        .swallow(swallow), .wrap(wrap)
    );

    psd_swallow_ctrl #(.MAIN_W(MAIN_W), .SWAL_W(SWAL_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wrap(wrap), .main_val(main_val),
        .swal_val(swal_val), .swallow(swallow), .loading(loading),
        .pulse(div_out), .half(div_half), .main_cnt(main_cnt), .swal_cnt(swal_cnt)
    );
endmodule

// File: rtl/psd_checker.sv
module psd_checker #(
    parameter int MAIN_W = 13,
    parameter int SWAL_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              div_out,
    input logic              div_half,
    input logic              loading,
    input logic [MAIN_W-1:0] main_cnt,
    input logic [SWAL_W-1:0] swal_cnt
);
    a_r1_quiet_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        loading |-> (!div_out && !div_half));

    a_r5_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        div_out |=> !div_out);

    a_r9_half_flips: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_out) |-> (div_half != $past(div_half)));

    a_r9_half_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!div_out && !loading) |=> (div_out || $stable(div_half)));

    a_r3_swallow_within_main: assert property (@(posedge clk) disable iff (!rst_n)
        !loading |-> ({{SWAL_W{1'b0}}, swal_cnt} <= {{SWAL_W{1'b0}}, main_cnt}));
endmodule

bind pulse_swallow_div psd_checker #(.MAIN_W(MAIN_W), .SWAL_W(SWAL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .div_out(div_out), .div_half(div_half),
    .loading(loading), .main_cnt(main_cnt), .swal_cnt(swal_cnt)
);

// File: tb/tb_pulse_swallow_div.sv
`timescale 1ns/1ps
module tb_pulse_swallow_div;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [16:0] ratio = 17'd480;
    logic        halve = 1'b0;
    logic        div_out;
    logic        div_half;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    pulse_swallow_div dut (
        .clk(clk), .rst_n(rst_n), .ratio(ratio), .halve(halve),
        .div_out(div_out), .div_half(div_half)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input int r, input bit h);
        @(negedge clk);
        rst_n = 1'b0;
        ratio = 17'(r);
        halve = h;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic to_pulse(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!div_out && n < 20000);
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(div_out == 1'b0, "R1 div_out in reset", int'(div_out), 0);
        check(div_half == 1'b0, "R1 div_half in reset", int'(div_half), 0);
    endtask

    task automatic t_plain;
        int n;
        do_reset(480, 1'b0);
        @(negedge clk);
        check(div_out == 1'b0 && div_half == 1'b0, "R1 quiet after release",
              int'(div_out) + int'(div_half), 0);
        to_pulse(n);
        check(n + 1 == 481, "R4 first pulse latency", n + 1, 481);
        check(div_half == 1'b1, "R9 half high on first pulse", int'(div_half), 1);
        to_pulse(n);
        check(n == 480, "R2 period A=0", n, 480);
        check(div_half == 1'b0, "R9 half low on second pulse", int'(div_half), 0);
        @(negedge clk);
        check(div_out == 1'b0, "R5 pulse one cycle", int'(div_out), 0);
        check(div_half == 1'b0, "R9 half holds after pulse", int'(div_half), 0);
    endtask

    task automatic t_swallow;
        int n;
        do_reset(327, 1'b0);
        to_pulse(n);
        check(n == 328, "R4 latency with swallow", n, 328);
        to_pulse(n);
        check(n == 327, "R3 period M=20 A=7", n, 327);
        do_reset(255, 1'b0);
        to_pulse(n);
        to_pulse(n);
        check(n == 255, "R3 period M=15 A=15", n, 255);
    endtask

    task automatic t_halve;
        int n;
        do_reset(300, 1'b1);
        to_pulse(n);
        to_pulse(n);
        check(n == 600, "R6 halved period", n, 600);
        @(negedge clk);
        check(div_out == 1'b0, "R5 pulse one cycle halved", int'(div_out), 0);
    endtask

    task automatic t_clamp;
        int n;
        do_reset(100, 1'b0);
        to_pulse(n);
        to_pulse(n);
        check(n == 240, "R7 clamp 100", n, 240);
        do_reset(0, 1'b0);
        to_pulse(n);
        to_pulse(n);
        check(n == 240, "R7 clamp 0", n, 240);
    endtask

    task automatic t_change;
        int n;
        do_reset(327, 1'b0);
        to_pulse(n);
        repeat (10) @(negedge clk);
        ratio = 17'd250;
        to_pulse(n);
        check(n == 317, "R8 cycle in progress keeps old ratio", n + 10, 327);
        to_pulse(n);
        check(n == 250, "R8 next cycle uses new ratio", n, 250);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_plain();
        t_swallow();
        t_halve();
        t_clamp();
        t_change();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule